// File: doc/BRIEF.md
# SMT Fetch Thread Selector

This block sits in front of the instruction fetch stage of a simultaneous multithreaded core. Each cycle it names up to `GRANTS` hardware threads that may fetch, and it gives each named thread a fixed allotment of `SLOTS` instructions. Its decision rests on three banks of per-thread counters that it keeps itself: instructions in flight in the front-end stages, unresolved branches, and outstanding data cache misses. Each counter moves by one step on a per-thread increment or decrement event.

A two-bit mode input picks the ranking policy. The first policy is a plain rotation. The other three each favour the threads with the smallest value in one of the three counter banks. Threads that share a value are ordered by their distance from a start pointer that rotates every cycle, so equal threads take turns. A per-thread eligibility mask removes stalled or idle threads from the choice. Grants are registered. Each grant lane carries a valid bit, a thread number and a slot count.

Top module: `fetch_sel`

## Requirements
- R1: While reset is asserted and right after it, every grant lane is invalid with thread number 0 and slot count 0. All counters are zero and the start pointer is 0.
- R2: With mode 0 (rotation), lane k holds the (k+1)-th eligible thread found by walking upward from the start pointer and wrapping past the last thread. The start pointer advances by one, modulo the thread count, on every clock edge after reset, whatever the mode.
- R3: With mode 1, lanes are filled in ascending order of the in-flight instruction counter.
- R4: With mode 2, lanes are filled in ascending order of the unresolved branch counter.
- R5: With mode 3, lanes are filled in ascending order of the outstanding miss counter.
- R6: Threads with equal counter values are ordered by their rotation distance (thread − pointer) mod thread count, so the thread at the pointer comes first.
- R7: A thread whose mask bit is 0 is never granted. Valid lanes are packed from lane 0 upward, and lanes beyond the number of eligible threads are invalid.
- R8: A counter at its maximum (2^CNT_W − 1) that receives only an increment keeps that maximum.
- R9: A counter at zero that receives only a decrement stays at zero.
- R10: An increment and a decrement for the same counter in the same cycle leave it unchanged.
- R11: Grants reflect the mode, mask, counters and pointer sampled at the clock edge and hold steady between edges. A valid lane reports a slot count equal to `SLOTS` and an invalid lane reports 0. No two valid lanes carry the same thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy: 0 rotation, 1 fewest instructions, 2 fewest branches, 3 fewest misses |
| active_mask | input | NUM_THREADS | 1 = thread may be granted |
| ic_inc | input | NUM_THREADS | Per-thread in-flight instruction increment |
| ic_dec | input | NUM_THREADS | Per-thread in-flight instruction decrement |
| br_inc | input | NUM_THREADS | Per-thread unresolved branch increment |
| br_dec | input | NUM_THREADS | Per-thread unresolved branch decrement |
| miss_inc | input | NUM_THREADS | Per-thread outstanding miss increment |
| miss_dec | input | NUM_THREADS | Per-thread outstanding miss decrement |
| grant_valid | output | GRANTS | Lane k holds a grant |
| grant_tid | output | GRANTS*TID_W | Thread number of lane k at bits [k*TID_W +: TID_W] |
| grant_slots | output | GRANTS*SLOT_W | Slot count of lane k at bits [k*SLOT_W +: SLOT_W] |

## Verification
A vector table drives each of the four policies with full, sparse and irregular masks, while event bursts push the counters apart. This shows that each policy reads its own counter bank and not a neighbouring one. A run of cycles with all counters equal isolates the rotating tie-break. Masks that allow zero or one thread show the packing and the invalid lanes. Long increment runs past the maximum, decrement runs below zero and paired increment/decrement bursts are each arranged so that a counter that wraps or drifts would reorder the winning lane, which makes the saturation and cancel rules visible at the grant ports.

// File: rtl/fetch_sel_pkg.sv
package fetch_sel_pkg;

  typedef enum logic [1:0] {
    SEL_ROTATE          = 2'd0,
    SEL_FEWEST_INSNS    = 2'd1,
    SEL_FEWEST_BRANCHES = 2'd2,
    SEL_FEWEST_MISSES   = 2'd3
  } sel_mode_e;

  // distance of thread t from pointer p on a ring of n threads
  function automatic int rot_dist(input int t, input int p, input int n);
    return (t >= p) ? (t - p) : (t + n - p);
  endfunction

  // one counter step: clamp at both ends, opposite events cancel
  function automatic int sat_step(input int cur, input logic up, input logic dn,
                                  input int maxv);
    if (up && !dn) return (cur == maxv) ? cur : cur + 1;
    if (dn && !up) return (cur == 0) ? cur : cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/fetch_sel_ctr.sv
module fetch_sel_ctr
  import fetch_sel_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int CNT_W       = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_THREADS-1:0]       inc,
  input  logic [NUM_THREADS-1:0]       dec,
  output logic [NUM_THREADS*CNT_W-1:0] cnt
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= CNT_W'(sat_step(int'(cnt_q), inc[t], dec[t], CNT_MAX));
    end
    assign cnt[t*CNT_W +: CNT_W] = cnt_q;
  end

endmodule

// File: rtl/fetch_sel_pick.sv
module fetch_sel_pick #(
  parameter int NUM_THREADS = 8,
  parameter int GRANTS      = 2,
  parameter int KEY_W       = 7,
  parameter int TID_W       = 3
) (
  input  logic [NUM_THREADS*KEY_W-1:0] keys,
  input  logic [NUM_THREADS-1:0]       elig,
  output logic [GRANTS-1:0]            vld,
  output logic [GRANTS*TID_W-1:0]      tid
);
  // GRANTS passes; each takes the smallest key not yet taken
  always_comb begin
    logic [NUM_THREADS-1:0] taken;
    logic [KEY_W-1:0]       best_key;
    int                     best_idx;
    taken = '0;
    vld   = '0;
    tid   = '0;
    for (int l = 0; l < GRANTS; l++) begin
      best_key = '0;
      best_idx = 0;
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (elig[t] && !taken[t] &&
            (!vld[l] || keys[t*KEY_W +: KEY_W] < best_key)) begin
          vld[l]   = 1'b1;
          best_key = keys[t*KEY_W +: KEY_W];
          best_idx = t;
        end
      end
      if (vld[l]) begin
        taken[best_idx]         = 1'b1;
        tid[l*TID_W +: TID_W]   = TID_W'(best_idx);
      end
    end
  end

endmodule

// File: rtl/fetch_sel.sv
module fetch_sel
  import fetch_sel_pkg::*;
#(
  parameter int NUM_THREADS = 8,
  parameter int GRANTS      = 2,
  parameter int SLOTS       = 4,
  parameter int CNT_W       = 4,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int SLOT_W     = $clog2(SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode,
  input  logic [NUM_THREADS-1:0]     active_mask,
  input  logic [NUM_THREADS-1:0]     ic_inc,
  input  logic [NUM_THREADS-1:0]     ic_dec,
  input  logic [NUM_THREADS-1:0]     br_inc,
  input  logic [NUM_THREADS-1:0]     br_dec,
  input  logic [NUM_THREADS-1:0]     miss_inc,
  input  logic [NUM_THREADS-1:0]     miss_dec,
  output logic [GRANTS-1:0]          grant_valid,
  output logic [GRANTS*TID_W-1:0]    grant_tid,
  output logic [GRANTS*SLOT_W-1:0]   grant_slots
);
  localparam int KEY_W = CNT_W + TID_W;

  // named internal events, watched by the checker
  logic [NUM_THREADS*CNT_W-1:0] ic_cnt, br_cnt, miss_cnt;
  logic [TID_W-1:0]             ptr;
  logic [NUM_THREADS*KEY_W-1:0] keys;
  logic [GRANTS-1:0]            sel_vld;
  logic [GRANTS*TID_W-1:0]      sel_tid;

  fetch_sel_ctr #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_ic_ctr (
    .clk(clk), .rst_n(rst_n), .inc(ic_inc), .dec(ic_dec), .cnt(ic_cnt));
  fetch_sel_ctr #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_br_ctr (
    .clk(clk), .rst_n(rst_n), .inc(br_inc), .dec(br_dec), .cnt(br_cnt));
  fetch_sel_ctr #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_miss_ctr (
    .clk(clk), .rst_n(rst_n), .inc(miss_inc), .dec(miss_dec), .cnt(miss_cnt));

  // key = {policy metric, rotation distance}; lower key wins
  always_comb begin
    logic [CNT_W-1:0] metric;
    for (int t = 0; t < NUM_THREADS; t++) begin
      unique case (sel_mode_e'(mode))
        SEL_FEWEST_INSNS:    metric = ic_cnt[t*CNT_W +: CNT_W];
        SEL_FEWEST_BRANCHES: metric = br_cnt[t*CNT_W +: CNT_W];
        SEL_FEWEST_MISSES:   metric = miss_cnt[t*CNT_W +: CNT_W];
        default:             metric = '0;
      endcase
      keys[t*KEY_W +: KEY_W] = {metric, TID_W'(rot_dist(t, int'(ptr), NUM_THREADS))};
    end
  end

  fetch_sel_pick #(.NUM_THREADS(NUM_THREADS), .GRANTS(GRANTS),
                   .KEY_W(KEY_W), .TID_W(TID_W)) u_pick (
    .keys(keys), .elig(active_mask), .vld(sel_vld), .tid(sel_tid));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_valid <= '0;
      grant_tid   <= '0;
      ptr         <= '0;
    end else begin
      grant_valid <= sel_vld;
      grant_tid   <= sel_tid;
      ptr         <= (int'(ptr) == NUM_THREADS - 1) ? '0 : ptr + 1'b1;
    end
  end

  for (genvar l = 0; l < GRANTS; l++) begin : g_slots
    assign grant_slots[l*SLOT_W +: SLOT_W] = grant_valid[l] ? SLOT_W'(SLOTS) : '0;
  end

endmodule

// File: rtl/fetch_sel_chk.sv
module fetch_sel_chk #(
  parameter int NUM_THREADS = 8,
  parameter int GRANTS      = 2,
  parameter int CNT_W       = 4,
  parameter int TID_W       = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_THREADS-1:0]       active_mask,
  input logic [NUM_THREADS-1:0]       ic_inc,
  input logic [NUM_THREADS-1:0]       ic_dec,
  input logic [NUM_THREADS*CNT_W-1:0] ic_cnt,
  input logic [TID_W-1:0]             ptr,
  input logic [GRANTS-1:0]            grant_valid,
  input logic [GRANTS*TID_W-1:0]      grant_tid
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [NUM_THREADS-1:0] mask_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= active_mask;
  end

  // R2
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (int'(ptr) == (int'($past(ptr)) + 1) % NUM_THREADS));

  for (genvar l = 0; l < GRANTS; l++) begin : g_lane
    // R7
    masked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid[l] |-> mask_q[grant_tid[l*TID_W +: TID_W]]);
    if (l > 0) begin : g_pack
      // R7
      lane_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid[l] |-> grant_valid[l-1]);
    end
    for (genvar m = l + 1; m < GRANTS; m++) begin : g_pair
      // R11
      distinct_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid[l] && grant_valid[m]) |->
          (grant_tid[l*TID_W +: TID_W] != grant_tid[m*TID_W +: TID_W]));
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cnt
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(ic_cnt[t*CNT_W +: CNT_W]) == CNT_MAX && ic_inc[t] && !ic_dec[t])
        |=> (int'(ic_cnt[t*CNT_W +: CNT_W]) == CNT_MAX));
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ic_cnt[t*CNT_W +: CNT_W] == '0 && ic_dec[t] && !ic_inc[t])
        |=> (ic_cnt[t*CNT_W +: CNT_W] == '0));
    // R10
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ic_inc[t] && ic_dec[t]) |=> $stable(ic_cnt[t*CNT_W +: CNT_W]));
  end

endmodule

bind fetch_sel fetch_sel_chk #(
  .NUM_THREADS(NUM_THREADS), .GRANTS(GRANTS), .CNT_W(CNT_W), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .active_mask(active_mask),
  .ic_inc(ic_inc), .ic_dec(ic_dec), .ic_cnt(ic_cnt), .ptr(ptr),
  .grant_valid(grant_valid), .grant_tid(grant_tid)
);

// File: tb/fetch_sel_tb.sv
module fetch_sel_tb;
  localparam int N = 8, X = 2, Y = 4, CW = 4;
  localparam int TW = 3, SW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic [N-1:0] active_mask = '0, ic_inc = '0, ic_dec = '0, br_inc = '0,
                br_dec = '0, miss_inc = '0, miss_dec = '0;
  logic [X-1:0]    grant_valid;
  logic [X*TW-1:0] grant_tid;
  logic [X*SW-1:0] grant_slots;

  fetch_sel u_dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model
  int m_ic[N], m_br[N], m_ms[N], m_ptr;
  logic [X-1:0]    e_v;
  logic [X*TW-1:0] e_t;
  logic [X*SW-1:0] e_s;

  // vector: {mode, mask, ic_inc, ic_dec, br_inc, br_dec, miss_inc, miss_dec}
  localparam logic [57:0] VEC [16] = '{
    {2'd0, 8'hFF, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'd0, 8'hA5, 8'h30, 8'h00, 8'h11, 8'h00, 8'h00, 8'h00},
    {2'd0, 8'h7E, 8'h00, 8'h01, 8'h00, 8'h00, 8'h22, 8'h00},
    {2'd1, 8'hFF, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'd1, 8'hFF, 8'h00, 8'h0F, 8'h40, 8'h00, 8'h00, 8'h00},
    {2'd1, 8'h3C, 8'h55, 8'hAA, 8'h00, 8'h00, 8'h00, 8'h00},
    {2'd1, 8'hF0, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h88, 8'h00},
    {2'd2, 8'hFF, 8'h00, 8'h00, 8'hF0, 8'h00, 8'h00, 8'h00},
    {2'd2, 8'hFF, 8'h00, 8'h00, 8'h0C, 8'h10, 8'h00, 8'h00},
    {2'd2, 8'h99, 8'h00, 8'h00, 8'h81, 8'h81, 8'h00, 8'h00},
    {2'd2, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00},
    {2'd3, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFE, 8'h00},
    {2'd3, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h01},
    {2'd3, 8'h0F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0C},
    {2'd3, 8'hE7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h10, 8'h00},
    {2'd1, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  function automatic int nxt(int c, logic u, logic d);
    if (u == d) return c;
    if (u) return (c < CMAX) ? c + 1 : CMAX;
    return (c > 0) ? c - 1 : 0;
  endfunction

  // expected grants: scan values upward, threads from the pointer around
  task automatic expect_from_model(input logic [1:0] md, input logic [N-1:0] msk);
    bit taken[N];
    int lane = 0;
    e_v = '0; e_t = '0; e_s = '0;
    for (int t = 0; t < N; t++) taken[t] = 0;
    for (int v = 0; v <= CMAX; v++) begin
      for (int k = 0; k < N; k++) begin
        int t = (m_ptr + k) % N;
        int met = (md == 2'd0) ? 0 : (md == 2'd1) ? m_ic[t] :
                  (md == 2'd2) ? m_br[t] : m_ms[t];
        if (lane < X && msk[t] && !taken[t] && met == v) begin
          taken[t] = 1;
          e_v[lane] = 1'b1;
          e_t[lane*TW +: TW] = TW'(t);
          e_s[lane*SW +: SW] = SW'(Y);
          lane++;
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    n_chk++;
    if (grant_valid !== e_v || grant_tid !== e_t || grant_slots !== e_s) begin
      n_bad++;
      $display("FAIL %s: valid/tid/slots actual %b/%h/%h expected %b/%h/%h",
               tag, grant_valid, grant_tid, grant_slots, e_v, e_t, e_s);
    end
  endtask

  // called at a negedge; returns at the next negedge after one edge
  task automatic step(input string tag, input logic [1:0] md, input logic [N-1:0] msk,
                      input logic [N-1:0] ii, id, bi, bd, mi, mdc);
    mode = md; active_mask = msk;
    ic_inc = ii; ic_dec = id; br_inc = bi; br_dec = bd; miss_inc = mi; miss_dec = mdc;
    expect_from_model(md, msk);
    @(posedge clk);
    for (int t = 0; t < N; t++) begin
      m_ic[t] = nxt(m_ic[t], ii[t], id[t]);
      m_br[t] = nxt(m_br[t], bi[t], bd[t]);
      m_ms[t] = nxt(m_ms[t], mi[t], mdc[t]);
    end
    m_ptr = (m_ptr + 1) % N;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag, input logic [1:0] md, input logic [N-1:0] msk, input int n);
    for (int i = 0; i < n; i++) step(tag, md, msk, '0, '0, '0, '0, '0, '0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    {ic_inc, ic_dec, br_inc, br_dec, miss_inc, miss_dec} = '0;
    repeat (2) @(negedge clk);
    for (int t = 0; t < N; t++) begin m_ic[t] = 0; m_br[t] = 0; m_ms[t] = 0; end
    m_ptr = 0;
    e_v = '0; e_t = '0; e_s = '0;
    compare("R1 during reset");
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: right after release, before any grant is computed from live inputs
    e_v = '0; e_t = '0; e_s = '0;
    compare("R1 after reset");

    // table walk, three passes so counters spread and pointer phases vary
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 16; i++) begin
        logic [57:0] v = VEC[i];
        string tag;
        case (v[57:56])
          2'd0: tag = "R2 rotation";
          2'd1: tag = "R3 fewest insns";
          2'd2: tag = "R4 fewest branches";
          default: tag = "R5 fewest misses";
        endcase
        step(tag, v[57:56], v[55:48], v[47:40], v[39:32], v[31:24], v[23:16],
             v[15:8], v[7:0]);
      end
    end

    // R6: all counters equal, pointer alone orders the lanes
    do_reset();
    idle("R6 tie order", 2'd1, 8'hFF, 10);
    idle("R6 tie order misses", 2'd3, 8'hFF, 3);

    // R7: empty and single-thread masks
    idle("R7 empty mask", 2'd0, 8'h00, 2);
    idle("R7 single thread", 2'd0, 8'h40, 3);
    idle("R7 two threads", 2'd2, 8'h81, 3);

    // R8: thread 0 pushed past max (17 incs), thread 1 to 14: thread 1 must lead
    do_reset();
    for (int i = 0; i < 14; i++) step("R8 fill", 2'd1, 8'h03, 8'h03, '0, '0, '0, '0, '0);
    for (int i = 0; i < 3; i++)  step("R8 overfill", 2'd1, 8'h03, 8'h01, '0, '0, '0, '0, '0);
    idle("R8 saturated order", 2'd1, 8'h03, 3);

    // R9: thread 2 drained below zero then one inc -> 1; thread 3 at 2
    do_reset();
    for (int i = 0; i < 3; i++) step("R9 drain", 2'd1, 8'h0C, '0, 8'h04, '0, '0, '0, '0);
    step("R9 inc", 2'd1, 8'h0C, 8'h04, '0, '0, '0, '0, '0);
    for (int i = 0; i < 2; i++) step("R9 other", 2'd1, 8'h0C, 8'h08, '0, '0, '0, '0, '0);
    idle("R9 clamp order", 2'd1, 8'h0C, 3);

    // R10: thread 4 gets paired inc/dec, thread 5 only incs
    do_reset();
    for (int i = 0; i < 2; i++) step("R10 load", 2'd3, 8'h30, '0, '0, '0, '0, 8'h10, '0);
    for (int i = 0; i < 3; i++) step("R10 paired", 2'd3, 8'h30, '0, '0, '0, '0, 8'h30, 8'h10);
    idle("R10 cancel order", 2'd3, 8'h30, 3);
    for (int i = 0; i < 3; i++) step("R10 branch paired", 2'd2, 8'h30, '0, '0, 8'h30, 8'h20, '0, '0);
    idle("R10 branch order", 2'd2, 8'h30, 2);

    // R11: inputs change mid-cycle, grants hold until the next edge
    step("R11 setup", 2'd0, 8'hFF, '0, '0, '0, '0, '0, '0);
    active_mask = 8'h00; mode = 2'd3; ic_inc = 8'hFF;
    #2;
    compare("R11 hold between edges");
    ic_inc = '0;
    idle("R11 after change", 2'd0, 8'h00, 1);
    idle("R11 recover", 2'd1, 8'h5A, 2);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule